// File: doc/BRIEF.md
# Lockstep Coprocessor Command Link

This block joins a scalar pipeline to a small set of tightly coupled coprocessors (two by default) so that both sides advance in lockstep. Each cycle the host may present one command: a valid flag, a coprocessor index, a 20-bit opcode and a 32-bit write word. The link forwards the opcode and write word to every coprocessor in the same cycle. It raises a per-coprocessor command strobe only on the addressed unit, and only while the host is not frozen.

Each coprocessor answers with its own 32-bit result bus and its own active-low hold. The link merges the holds into one host hold and remembers which unit owes the result of the most recent read. It steers that unit's result bus back to the host. A read normally completes in the cycle after issue. Holds stretch it by whole cycles, and the remembered selection stays fixed for the length of the stall.

The two top bits of the opcode, bits 19:18, give the command class. 00 is a data operation, 01 is a host-to-coprocessor register write, 10 is a coprocessor-to-host register read, and 11 is reserved and handled like a data operation.

Top module: `cop_link`

## Requirements
- R1: While reset is high and in the first cycle after it, `h_rvalid` is 0 and `h_rdata` is zero.
- R2: A command is accepted when `h_valid` is 1 and `h_hold_n` is 1. In that cycle `c_valid` is one-hot, with bit `h_sel` set, and `c_opc` and `c_wdata` equal `h_opc` and `h_wdata`, including for writes (class 01).
- R3: When `h_valid` is 0, `c_valid` is all zero whatever the other host inputs are.
- R4: `h_hold_n` is the AND of all bits of `c_hold_n`, combinationally.
- R5: A read (class 10) accepted in cycle N with all holds high in cycle N+1 gives `h_rvalid`=1 in N+1, and `h_rdata` equals the result bus of coprocessor `h_sel` as sampled at issue.
- R6: If any hold is low in the cycle after a read is accepted, `h_rvalid` stays 0 until the first cycle in which all holds are high. In that cycle the result comes from the coprocessor chosen at issue, even if `h_sel` has changed since.
- R7: A data operation, a write and a read may be issued in three consecutive cycles, and reads may follow each other every cycle; each read returns in the following cycle.
- R8: While `h_hold_n` is 0, `c_valid` is all zero even if the host keeps `h_valid` high, and no new read is recorded.
- R9: A cycle with no pending read (after a non-read command, an idle cycle or a delivered result) shows `h_rvalid`=0 and `h_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host command valid |
| h_sel | input | 1 | Target coprocessor index |
| h_opc | input | 20 | Opcode; bits 19:18 are the command class |
| h_wdata | input | 32 | Host write word |
| h_hold_n | output | 1 | Merged active-low hold to the host |
| h_rvalid | output | 1 | Read result valid this cycle |
| h_rdata | output | 32 | Read result, zero when no read pending |
| c_valid | output | 2 | Per-coprocessor command strobe |
| c_opc | output | 20 | Opcode broadcast |
| c_wdata | output | 32 | Write word broadcast |
| c_hold_n | input | 2 | Per-coprocessor active-low hold |
| c_rdata | input | 64 | Result buses, coprocessor i at bits 32*i+31:32*i |

## Verification
If the remembered read selection goes wrong, `h_rdata` carries the other unit's result in the very cycle the read completes. If the pending flag is lost or left stale, `h_rvalid` fails to rise, or rises on an idle cycle, one cycle after the offending command. A stall that does not freeze the tracker shows up as an early `h_rvalid` during the hold, or as data from the wrong unit on the release cycle. A broken issue gate shows up at once on `c_valid` in the same cycle as the hold.

// File: rtl/cop_link_pkg.sv
package cop_link_pkg;

    localparam int LINK_OPC_W = 20;
    localparam int LINK_DW    = 32;
    localparam int CLS_W      = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_DATA = 2'b00,
        CLS_WR   = 2'b01,
        CLS_RD   = 2'b10,
        CLS_RSV  = 2'b11
    } op_cls_e;

    // Command class lives in the top bits of the opcode field.
    function automatic op_cls_e op_class(input logic [CLS_W-1:0] top_bits);
        return op_cls_e'(top_bits);
    endfunction

endpackage

// File: rtl/cop_hold_merge.sv
module cop_hold_merge #(
    parameter int NCOP = 2
) (
    input  logic [NCOP-1:0] c_hold_n,
    output logic            hold_n
);
    // Any coprocessor pulling its hold low freezes the host.
    assign hold_n = &c_hold_n;
endmodule

// File: rtl/cop_route.sv
module cop_route
    import cop_link_pkg::*;
#(
    parameter int NCOP  = 2,
    parameter int SEL_W = 1,
    parameter int OPC_W = 20,
    parameter int DW    = 32
) (
    input  logic             h_valid,
    input  logic [SEL_W-1:0] h_sel,
    input  logic [OPC_W-1:0] h_opc,
    input  logic [DW-1:0]    h_wdata,
    input  logic             go,
    output logic [NCOP-1:0]  c_valid,
    output logic [OPC_W-1:0] c_opc,
    output logic [DW-1:0]    c_wdata,
    output logic             rd_issue
);
    logic    accept;
    op_cls_e cls;

    assign accept = h_valid && go;
    assign cls    = op_class(h_opc[OPC_W-1 -: CLS_W]);

    // Opcode and write word reach every unit in the issue cycle.
    assign c_opc   = h_opc;
    assign c_wdata = h_wdata;

    for (genvar i = 0; i < NCOP; i++) begin : g_strobe
        assign c_valid[i] = accept && (h_sel == SEL_W'(i));
    end

    assign rd_issue = accept && (cls == CLS_RD);
endmodule

// File: rtl/cop_rd_track.sv
module cop_rd_track #(
    parameter int NCOP  = 2,
    parameter int SEL_W = 1,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_issue,
    input  logic [SEL_W-1:0] issue_sel,
    input  logic             hold_n,
    input  logic [NCOP*DW-1:0] c_rdata,
    output logic             h_rvalid,
    output logic [DW-1:0]    h_rdata
);
    logic             pend_v;
    logic [SEL_W-1:0] pend_sel;

    // Frozen while any hold is low; otherwise retire and refill in one step.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_sel <= '0;
        end else if (hold_n) begin
            pend_v   <= rd_issue;
            pend_sel <= issue_sel;
        end
    end

    always_comb begin
        h_rdata = '0;
        for (int i = 0; i < NCOP; i++) begin
            if (pend_v && (pend_sel == SEL_W'(i)))
                h_rdata = c_rdata[i*DW +: DW];
        end
    end

    assign h_rvalid = pend_v && hold_n;

    // R5
    read_recorded_chk: assert property (@(posedge clk) disable iff (rst)
        rd_issue |=> pend_v);

    // R6
    stall_keeps_target_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !hold_n) |=> (pend_v && $stable(pend_sel)));

    // R9
    no_phantom_read_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_n && !rd_issue) |=> !h_rvalid);
endmodule

// File: rtl/cop_link.sv
module cop_link
    import cop_link_pkg::*;
#(
    parameter int NCOP  = 2,
    parameter int OPC_W = LINK_OPC_W,
    parameter int DW    = LINK_DW,
    localparam int SEL_W = (NCOP > 1) ? $clog2(NCOP) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_valid,
    input  logic [SEL_W-1:0]   h_sel,
    input  logic [OPC_W-1:0]   h_opc,
    input  logic [DW-1:0]      h_wdata,
    output logic               h_hold_n,
    output logic               h_rvalid,
    output logic [DW-1:0]      h_rdata,
    output logic [NCOP-1:0]    c_valid,
    output logic [OPC_W-1:0]   c_opc,
    output logic [DW-1:0]      c_wdata,
    input  logic [NCOP-1:0]    c_hold_n,
    input  logic [NCOP*DW-1:0] c_rdata
);
    logic rd_issue;

    cop_hold_merge #(.NCOP(NCOP)) u_merge (
        .c_hold_n (c_hold_n),
        .hold_n   (h_hold_n)
    );

    cop_route #(.NCOP(NCOP), .SEL_W(SEL_W), .OPC_W(OPC_W), .DW(DW)) u_route (
        .h_valid  (h_valid),
        .h_sel    (h_sel),
        .h_opc    (h_opc),
        .h_wdata  (h_wdata),
        .go       (h_hold_n),
        .c_valid  (c_valid),
        .c_opc    (c_opc),
        .c_wdata  (c_wdata),
        .rd_issue (rd_issue)
    );

    cop_rd_track #(.NCOP(NCOP), .SEL_W(SEL_W), .DW(DW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (rd_issue),
        .issue_sel (h_sel),
        .hold_n    (h_hold_n),
        .c_rdata   (c_rdata),
        .h_rvalid  (h_rvalid),
        .h_rdata   (h_rdata)
    );

    // R2
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(c_valid));

    // R8
    frozen_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        !h_hold_n |-> (c_valid == '0));
endmodule

// File: tb/sim_cop_link.sv
module sim_cop_link;
    logic        clk = 1'b0;
    logic        rst;
    logic        h_valid;
    logic [0:0]  h_sel;
    logic [19:0] h_opc;
    logic [31:0] h_wdata;
    logic        h_hold_n;
    logic        h_rvalid;
    logic [31:0] h_rdata;
    logic [1:0]  c_valid;
    logic [19:0] c_opc;
    logic [31:0] c_wdata;
    logic [1:0]  c_hold_n;
    logic [63:0] c_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    // Bench model of the outstanding read
    bit       m_pend = 0;
    bit [0:0] m_sel  = 0;

    always #4 clk = ~clk;

    cop_link u0 (
        .clk(clk), .rst(rst), .h_valid(h_valid), .h_sel(h_sel), .h_opc(h_opc),
        .h_wdata(h_wdata), .h_hold_n(h_hold_n), .h_rvalid(h_rvalid),
        .h_rdata(h_rdata), .c_valid(c_valid), .c_opc(c_opc), .c_wdata(c_wdata),
        .c_hold_n(c_hold_n), .c_rdata(c_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // One host cycle: drive at falling edge, check, then model the rising edge.
    task automatic step(input bit v, input bit [0:0] s, input bit [1:0] cls,
                        input bit [1:0] hv, input string tag);
        bit         all;
        bit [1:0]   exp_cv;
        bit [31:0]  r0, r1, exp_rd;
        string      t_cv, t_rv;
        @(negedge clk);
        cyc++;
        r0 = 32'hA000_0000 | 32'(cyc);
        r1 = 32'hB000_0000 | 32'(cyc);
        h_valid  = v;
        h_sel    = s;
        h_opc    = {cls, 18'(cyc * 37)};
        h_wdata  = 32'h5000_0000 ^ 32'(cyc * 101);
        c_hold_n = hv;
        c_rdata  = {r1, r0};
        #1;
        all    = &hv;
        exp_cv = (v && all) ? (2'b01 << s) : 2'b00;
        t_cv   = !v ? "R3" : (!all ? "R8" : "R2");
        chk(c_valid == exp_cv, t_cv, 64'(c_valid), 64'(exp_cv));
        chk(c_opc == h_opc && c_wdata == h_wdata, "R2",
            {12'h0, c_opc, c_wdata}, {12'h0, h_opc, h_wdata});
        chk(h_hold_n == all, "R4", 64'(h_hold_n), 64'(all));
        exp_rd = m_pend ? (m_sel ? r1 : r0) : 32'h0;
        t_rv   = (tag != "") ? tag : (!m_pend ? "R9" : (all ? "R5" : "R6"));
        chk(h_rvalid == (m_pend && all), t_rv, 64'(h_rvalid), 64'(m_pend && all));
        chk(h_rdata == exp_rd, t_rv, 64'(h_rdata), 64'(exp_rd));
        if (all) begin
            m_pend = v && (cls == 2'b10);
            m_sel  = s;
        end
    endtask

    initial begin
        rst = 1'b1; h_valid = 0; h_sel = 0; h_opc = 0; h_wdata = 0;
        c_hold_n = 2'b11; c_rdata = 64'h0;
        repeat (3) @(negedge clk);
        #1;
        chk(h_rvalid == 0 && h_rdata == 0, "R1", {31'h0, h_rvalid, h_rdata}, 64'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(h_rvalid == 0 && h_rdata == 0, "R1", {31'h0, h_rvalid, h_rdata}, 64'h0);

        // Sweep every valid/select/class/hold combination, each after a read to
        // both targets so stalls and releases hit a live pending read.
        for (int v = 0; v < 2; v++)
            for (int s = 0; s < 2; s++)
                for (int c = 0; c < 4; c++)
                    for (int h = 0; h < 4; h++) begin
                        step(1, 1'(h & 1), 2'b10, 2'b11, "");
                        step(v[0], s[0], c[1:0], h[1:0], "");
                        step(0, 0, 2'b00, 2'b11, "");
                    end

        // R7: data op, write, read back to back, then reads every cycle
        step(1, 0, 2'b00, 2'b11, "R7");
        step(1, 1, 2'b01, 2'b11, "R7");
        step(1, 1, 2'b10, 2'b11, "R7");
        step(1, 0, 2'b10, 2'b11, "R7");
        step(1, 1, 2'b10, 2'b11, "R7");
        step(0, 0, 2'b00, 2'b11, "R7");

        // R6: read to unit 1 stalled two cycles while host inputs change
        step(1, 1, 2'b10, 2'b11, "");
        step(1, 0, 2'b10, 2'b01, "R6");
        step(1, 0, 2'b10, 2'b01, "R6");
        step(0, 0, 2'b00, 2'b11, "R6");
        step(0, 0, 2'b00, 2'b11, "R9");

        // R6: read to unit 0 stalled by unit 0, released with a new read
        step(1, 0, 2'b10, 2'b11, "");
        step(1, 1, 2'b10, 2'b10, "R6");
        step(1, 1, 2'b10, 2'b11, "R6");
        step(0, 0, 2'b00, 2'b11, "R5");
        step(0, 0, 2'b00, 2'b11, "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule